// File: doc/BRIEF.md
# DAC Conversion Trigger Controller

This block is the digital control logic that sits in front of a 12-bit digital-to-analog converter. Software programs a control word, loads a data word and may pulse a software trigger through a small register write/read port. The block decides when a conversion starts. The start can come from a data write, a software strobe, an external pin, one of four timer pulses or one of four PWM pulses. The external pin can be sensed by level or by edge. The block aligns the code, drives the code and a one-cycle start pulse to the converter, and keeps a busy indication for a fixed conversion time. It then raises a done flag.

In hardware-trigger operation the block can ask a DMA engine for the next data word on every hardware start. If a further hardware start arrives before that request has been answered, the block records an under-run and converts the old code again. Two flags can each be enabled onto a single interrupt line.

Register map (word address on `bus_addr`):
- 0: control
- 1: data
- 2: status
- 3: software trigger

Top module: `dac_trig_ctrl`

## Requirements
- R1: With control bit 0 (trigger enable) clear, a write to the data register starts exactly one conversion. The code is taken from the written word.
- R2: Writing 1 to bit 0 of the software-trigger register (address 3) starts one conversion when trigger enable is set and the source field (control bits [4:1]) is 0. Reading address 3 always returns 0.
- R3: With source 1, the external pin is sensed as set by control bits [6:5]: 0 low level, 1 high level, 2 falling edge, 3 rising edge. A pin change that does not match the selected sense starts nothing.
- R4: Sources 2..5 select timer inputs 0..3 and sources 6..9 select PWM inputs 0..3. A rising edge on the selected input, after a two-flop synchronizer, starts one conversion. Inputs that are not selected have no effect.
- R5: With control bit 7 clear, the code is data bits [11:0]. With it set, the code is data bits [15:4]. All other data bits are ignored.
- R6: Busy (status bit 8 and the `busy` port) rises together with the one-cycle start pulse and stays high for CONV_CYCLES cycles. Starts requested while busy are ignored.
- R7: Status bit 0 (done) sets when busy falls. Status bit 1 (under-run) sets on an under-run. Writing 1 to either bit clears it, and writing 0 leaves it unchanged.
- R8: With control bit 8 (DMA enable) set, each start from sources 1..9 raises `dma_req`. A later write to the data register lowers it.
- R9: A hardware start that arrives while DMA is enabled, `dma_req` is still high and no data write is in progress sets the under-run flag. That conversion reuses the previous code.
- R10: `irq` is high one cycle after (done AND control bit 9) OR (under-run AND control bit 10).
- R11: Control bit 11 (group enable) reads back as written and does not change conversion behaviour.
- R12: After reset, the control and status registers read 0, and `dac_start`, `busy`, `dma_req`, `irq` and `dac_code` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register word address |
| bus_wdata | input | BUS_W | Write data |
| bus_rdata | output | BUS_W | Read data, registered one cycle after the address |
| ext_pin | input | 1 | External asynchronous trigger pin |
| tmr_trig | input | N_TMR | Timer trigger pulses |
| pwm_trig | input | N_PWM | PWM trigger pulses |
| dac_code | output | CODE_W | Aligned code to the converter |
| dac_start | output | 1 | One-cycle conversion start |
| busy | output | 1 | Conversion in progress |
| dma_req | output | 1 | Request for the next data word |
| irq | output | 1 | Combined interrupt |

## Verification
The hardest case to reach from the ports is the under-run. It needs DMA enabled, a hardware trigger whose request stays unanswered through a whole conversion, and then a second synchronized trigger edge. The bench pulses a timer input and withholds the data write. After busy drops, it pulses the timer again. It then checks the flag, the interrupt and that the repeated code equals the earlier one. Level-sensed pin triggers are held for less than one conversion time, so a single start is the only correct result.

// File: rtl/dac_trig_pkg.sv
package dac_trig_pkg;
  localparam int CTRL_W = 12;

  typedef struct packed {
    logic       group_en;   // bit 11
    logic       udr_ie;     // bit 10
    logic       done_ie;    // bit 9
    logic       dma_en;     // bit 8
    logic       left_align; // bit 7
    logic [1:0] pin_mode;   // bits 6:5
    logic [3:0] src_sel;    // bits 4:1
    logic       trig_en;    // bit 0
  } ctrl_t;

  localparam logic [1:0] ADR_CTRL = 2'd0;
  localparam logic [1:0] ADR_DATA = 2'd1;
  localparam logic [1:0] ADR_STAT = 2'd2;
  localparam logic [1:0] ADR_SWTR = 2'd3;

  localparam logic [3:0] SRC_SW  = 4'd0;
  localparam logic [3:0] SRC_PIN = 4'd1;
  localparam int         SRC_TMR0 = 2;

  localparam logic [1:0] PIN_LOW  = 2'd0;
  localparam logic [1:0] PIN_HIGH = 2'd1;
  localparam logic [1:0] PIN_FALL = 2'd2;
  localparam logic [1:0] PIN_RISE = 2'd3;
endpackage

// File: rtl/dac_trig_sync.sv
module dac_trig_sync #(
  parameter int N = 9
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] async_in,
  output logic [N-1:0] lvl,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);
  logic [N-1:0] s1, s2, s3;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= '0;
      s2 <= '0;
      s3 <= '0;
    end else begin
      s1 <= async_in;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign lvl  = s2;
  assign rise = s2 & ~s3;
  assign fall = ~s2 & s3;
endmodule

// File: rtl/dac_trig_sel.sv
module dac_trig_sel
  import dac_trig_pkg::*;
#(
  parameter int N_TMR = 4,
  parameter int N_PWM = 4
) (
  input  ctrl_t            ctrl,
  input  logic             busy,
  input  logic             data_wr,
  input  logic             sw_pulse,
  input  logic             pin_lvl,
  input  logic             pin_rise,
  input  logic             pin_fall,
  input  logic [N_TMR-1:0] tmr_rise,
  input  logic [N_PWM-1:0] pwm_rise,
  output logic             fire,
  output logic             hw_fire
);
  localparam int PWM_BASE = SRC_TMR0 + N_TMR;

  logic cand;

  always_comb begin
    cand = 1'b0;
    if (!ctrl.trig_en) begin
      cand = data_wr;
    end else if (ctrl.src_sel == SRC_SW) begin
      cand = sw_pulse;
    end else if (ctrl.src_sel == SRC_PIN) begin
      case (ctrl.pin_mode)
        PIN_LOW:  cand = ~pin_lvl;
        PIN_HIGH: cand = pin_lvl;
        PIN_FALL: cand = pin_fall;
        default:  cand = pin_rise;
      endcase
    end else begin
      for (int i = 0; i < N_TMR; i++)
        if (ctrl.src_sel == 4'(SRC_TMR0 + i)) cand = tmr_rise[i];
      for (int j = 0; j < N_PWM; j++)
        if (ctrl.src_sel == 4'(PWM_BASE + j)) cand = pwm_rise[j];
    end
  end

  assign fire    = cand & ~busy;
  assign hw_fire = fire & ctrl.trig_en & (ctrl.src_sel != SRC_SW);
endmodule

// File: rtl/dac_conv_seq.sv
module dac_conv_seq #(
  parameter int CONV_CYCLES = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic fire,
  output logic start,
  output logic busy,
  output logic done
);
  localparam int CNT_W = $clog2(CONV_CYCLES + 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      start <= 1'b0;
      busy  <= 1'b0;
      done  <= 1'b0;
      cnt   <= '0;
    end else begin
      start <= fire;
      done  <= 1'b0;
      if (fire) begin
        busy <= 1'b1;
        cnt  <= CNT_W'(CONV_CYCLES - 1);
      end else if (busy) begin
        if (cnt == '0) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end

  p_start_one_cycle_r6: assert property (@(posedge clk) disable iff (rst)
    start |=> !start);
  p_start_with_busy_r6: assert property (@(posedge clk) disable iff (rst)
    start |-> busy);
  p_done_on_busy_fall_r7: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));
endmodule

// File: rtl/dac_trig_ctrl.sv
module dac_trig_ctrl
  import dac_trig_pkg::*;
#(
  parameter int BUS_W       = 32,
  parameter int CODE_W      = 12,
  parameter int CONV_CYCLES = 8,
  parameter int N_TMR       = 4,
  parameter int N_PWM       = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [1:0]        bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic              ext_pin,
  input  logic [N_TMR-1:0]  tmr_trig,
  input  logic [N_PWM-1:0]  pwm_trig,
  output logic [CODE_W-1:0] dac_code,
  output logic              dac_start,
  output logic              busy,
  output logic              dma_req,
  output logic              irq
);
  localparam int N_IN  = 1 + N_TMR + N_PWM;
  localparam int L_LO  = 16 - CODE_W;

  ctrl_t             ctrl_q;
  logic [BUS_W-1:0]  data_q;
  logic              fin_q, udr_q;
  logic              wr_ctrl, wr_data, wr_stat, sw_pulse;
  logic [N_IN-1:0]   s_lvl, s_rise, s_fall;
  logic              fire, hw_fire, done;
  logic [BUS_W-1:0]  code_src;
  logic              udr_evt;

  assign wr_ctrl  = bus_wr && (bus_addr == ADR_CTRL);
  assign wr_data  = bus_wr && (bus_addr == ADR_DATA);
  assign wr_stat  = bus_wr && (bus_addr == ADR_STAT);
  assign sw_pulse = bus_wr && (bus_addr == ADR_SWTR) && bus_wdata[0];

  dac_trig_sync #(.N(N_IN)) u_sync (
    .clk(clk), .rst(rst),
    .async_in({pwm_trig, tmr_trig, ext_pin}),
    .lvl(s_lvl), .rise(s_rise), .fall(s_fall)
  );

  dac_trig_sel #(.N_TMR(N_TMR), .N_PWM(N_PWM)) u_sel (
    .ctrl(ctrl_q), .busy(busy), .data_wr(wr_data), .sw_pulse(sw_pulse),
    .pin_lvl(s_lvl[0]), .pin_rise(s_rise[0]), .pin_fall(s_fall[0]),
    .tmr_rise(s_rise[N_TMR:1]), .pwm_rise(s_rise[N_IN-1:N_TMR+1]),
    .fire(fire), .hw_fire(hw_fire)
  );

  dac_conv_seq #(.CONV_CYCLES(CONV_CYCLES)) u_seq (
    .clk(clk), .rst(rst), .fire(fire),
    .start(dac_start), .busy(busy), .done(done)
  );

  assign code_src = wr_data ? bus_wdata : data_q;
  assign udr_evt  = hw_fire && ctrl_q.dma_en && dma_req && !wr_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= '0;
      data_q    <= '0;
      dac_code  <= '0;
      fin_q     <= 1'b0;
      udr_q     <= 1'b0;
      dma_req   <= 1'b0;
      irq       <= 1'b0;
      bus_rdata <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
      if (wr_data) data_q <= bus_wdata;
      if (fire)
        dac_code <= ctrl_q.left_align ? code_src[L_LO +: CODE_W]
                                      : code_src[CODE_W-1:0];
      if (hw_fire && ctrl_q.dma_en) dma_req <= 1'b1;
      else if (wr_data)             dma_req <= 1'b0;
      if (done)                           fin_q <= 1'b1;
      else if (wr_stat && bus_wdata[0])   fin_q <= 1'b0;
      if (udr_evt)                        udr_q <= 1'b1;
      else if (wr_stat && bus_wdata[1])   udr_q <= 1'b0;
      irq <= (fin_q & ctrl_q.done_ie) | (udr_q & ctrl_q.udr_ie);
      case (bus_addr)
        ADR_CTRL: bus_rdata <= BUS_W'(ctrl_q);
        ADR_DATA: bus_rdata <= data_q;
        ADR_STAT: bus_rdata <= BUS_W'({busy, 6'b0, udr_q, fin_q});
        default:  bus_rdata <= '0;
      endcase
    end
  end

  p_swtr_reads_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == ADR_SWTR) |=> (bus_rdata == '0));
  p_start_from_idle_r6: assert property (@(posedge clk) disable iff (rst)
    dac_start |-> !$past(busy));
  p_udr_needs_req_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(udr_q) |-> $past(dma_req));
  p_irq_has_flag_r10: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(fin_q | udr_q));
endmodule

// File: tb/dac_trig_ctrl_tb_top.sv
module dac_trig_ctrl_tb_top;
  localparam int CONV = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        ext_pin = 1'b1;
  logic [3:0]  tmr_trig = '0;
  logic [3:0]  pwm_trig = '0;
  logic [11:0] dac_code;
  logic        dac_start, busy, dma_req, irq;

  int n_tests = 0;
  int n_fail  = 0;
  int n_start = 0;
  logic [11:0] last_code = '0;
  int busy_len = 0;
  int last_busy_len = 0;
  bit done_flag = 0;

  always #10 clk = ~clk;

  dac_trig_ctrl #(.CONV_CYCLES(CONV)) dut_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_pin(ext_pin),
    .tmr_trig(tmr_trig), .pwm_trig(pwm_trig), .dac_code(dac_code),
    .dac_start(dac_start), .busy(busy), .dma_req(dma_req), .irq(irq)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (dac_start) begin
        n_start++;
        last_code = dac_code;
      end
      if (busy) busy_len++;
      else if (busy_len != 0) begin
        last_busy_len = busy_len;
        busy_len = 0;
      end
    end
  end

  function automatic logic [31:0] ctl(bit en, int sel, int mode, bit left,
                                      bit dma, bit die, bit uie, bit grp);
    return 32'(en) | 32'(sel << 1) | 32'(mode << 5) | 32'(left) << 7 |
           32'(dma) << 8 | 32'(die) << 9 | 32'(uie) << 10 | 32'(grp) << 11;
  endfunction

  function automatic logic [11:0] exp_code(logic [31:0] d, bit left);
    return left ? d[15:4] : d[11:0];
  endfunction

  task automatic check(bit ok, string req, longint act, longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = 2'd0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    bus_addr = 2'd0;
  endtask

  task automatic settle();
    repeat (CONV + 8) @(negedge clk);
  endtask

  task automatic pulse_tmr(int i);
    @(negedge clk); tmr_trig[i] = 1'b1;
    repeat (2) @(negedge clk); tmr_trig[i] = 1'b0;
  endtask

  task automatic pulse_pwm(int i);
    @(negedge clk); pwm_trig[i] = 1'b1;
    repeat (2) @(negedge clk); pwm_trig[i] = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] r, d;
    int s0, sel;
    bit left;
    void'($urandom(32'h5eed_0042));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R12 reset state
    check({dac_start, busy, dma_req, irq} == 4'b0 && dac_code == 0, "R12 outputs",
          {dac_start, busy, dma_req, irq, dac_code}, 0);
    rd(2'd0, r); check(r == 0, "R12 ctrl", r, 0);
    rd(2'd2, r); check(r == 0, "R12 status", r, 0);

    // R1 + R5 data write trigger, directed
    s0 = n_start;
    wr(2'd1, 32'hFFFF_FABC); settle();
    check(n_start == s0 + 1, "R1 count", n_start - s0, 1);
    check(last_code == 12'hABC, "R5 right", last_code, 12'hABC);
    wr(2'd0, ctl(0, 0, 0, 1, 0, 0, 0, 0));
    s0 = n_start;
    wr(2'd1, 32'h1234_5678); settle();
    check(last_code == 12'h567, "R5 left", last_code, 12'h567);

    // R6 busy length and done flag, R7 W1C
    check(last_busy_len == CONV, "R6 busy len", last_busy_len, CONV);
    rd(2'd2, r); check(r[0] == 1'b1, "R7 done set", r[0], 1);
    wr(2'd2, 32'h0); rd(2'd2, r); check(r[0] == 1'b1, "R7 write0 keeps", r[0], 1);
    wr(2'd2, 32'h1); rd(2'd2, r); check(r[0] == 1'b0, "R7 clear", r[0], 0);

    // R2 software trigger, repeat while busy ignored (R6)
    wr(2'd0, ctl(1, 0, 0, 0, 0, 0, 0, 0));
    wr(2'd1, 32'h0000_0321);
    s0 = n_start;
    check(n_start == s0, "R1 no start in trig mode", 0, 0);
    wr(2'd3, 32'h1); wr(2'd3, 32'h1); settle();
    check(n_start == s0 + 1, "R2/R6 busy ignore", n_start - s0, 1);
    check(last_code == 12'h321, "R2 code", last_code, 12'h321);
    rd(2'd3, r); check(r == 0, "R2 reads zero", r, 0);
    rd(2'd2, r); check(r[8] == 1'b0, "R6 status busy idle", r[8], 0);

    // R3 external pin modes
    ext_pin = 1'b1;
    wr(2'd0, ctl(1, 1, 0, 0, 0, 0, 0, 0)); settle();
    s0 = n_start;
    ext_pin = 1'b0; repeat (3) @(negedge clk); ext_pin = 1'b1; settle();
    check(n_start == s0 + 1, "R3 low level", n_start - s0, 1);
    ext_pin = 1'b0;
    wr(2'd0, ctl(1, 1, 1, 0, 0, 0, 0, 0)); settle();
    s0 = n_start;
    ext_pin = 1'b1; repeat (3) @(negedge clk); ext_pin = 1'b0; settle();
    check(n_start == s0 + 1, "R3 high level", n_start - s0, 1);
    wr(2'd0, ctl(1, 1, 2, 0, 0, 0, 0, 0)); settle();
    s0 = n_start;
    ext_pin = 1'b1; settle();
    check(n_start == s0, "R3 fall ignores rise", n_start - s0, 0);
    ext_pin = 1'b0; settle();
    check(n_start == s0 + 1, "R3 falling edge", n_start - s0, 1);
    wr(2'd0, ctl(1, 1, 3, 0, 0, 0, 0, 0)); settle();
    s0 = n_start;
    ext_pin = 1'b1; settle(); ext_pin = 1'b0; settle();
    check(n_start == s0 + 1, "R3 rising edge", n_start - s0, 1);

    // R4 timer and PWM selection, random order
    for (int k = 0; k < 8; k++) begin
      sel = 2 + int'($urandom_range(7));
      wr(2'd0, ctl(1, sel, 0, 0, 0, 0, 0, 0));
      s0 = n_start;
      for (int i = 0; i < 4; i++) begin
        if (sel != 2 + i) pulse_tmr(i);
        if (sel != 6 + i) pulse_pwm(i);
      end
      settle();
      check(n_start == s0, "R4 unselected ignored", n_start - s0, 0);
      if (sel < 6) pulse_tmr(sel - 2); else pulse_pwm(sel - 6);
      settle();
      check(n_start == s0 + 1, "R4 selected fires", n_start - s0, 1);
    end

    // R8 / R9 / R10 DMA and under-run
    wr(2'd2, 32'h3);
    wr(2'd0, ctl(1, 2, 0, 0, 1, 0, 1, 0));
    wr(2'd1, 32'h0000_0AAA);
    pulse_tmr(0); settle();
    check(dma_req == 1'b1, "R8 req raised", dma_req, 1);
    check(last_code == 12'hAAA, "R8 code", last_code, 12'hAAA);
    wr(2'd1, 32'h0000_0555);
    @(negedge clk);
    check(dma_req == 1'b0, "R8 req cleared", dma_req, 0);
    pulse_tmr(0); settle();
    check(last_code == 12'h555, "R8 new code", last_code, 12'h555);
    rd(2'd2, r); check(r[1] == 1'b0, "R9 no udr", r[1], 0);
    pulse_tmr(0); settle();
    rd(2'd2, r); check(r[1] == 1'b1, "R9 udr set", r[1], 1);
    check(last_code == 12'h555, "R9 old code reused", last_code, 12'h555);
    check(irq == 1'b1, "R10 udr irq", irq, 1);
    wr(2'd2, 32'h2); repeat (2) @(negedge clk);
    check(irq == 1'b0, "R10 irq cleared", irq, 0);
    rd(2'd2, r); check(r[1] == 1'b0, "R7 udr clear", r[1], 0);

    // R10 done interrupt, R11 group bit
    wr(2'd0, ctl(0, 0, 0, 0, 0, 1, 0, 1));
    rd(2'd0, r); check(r == ctl(0, 0, 0, 0, 0, 1, 0, 1), "R11 readback", r, ctl(0,0,0,0,0,1,0,1));
    s0 = n_start;
    wr(2'd1, 32'h0000_0777); settle();
    check(n_start == s0 + 1 && last_code == 12'h777, "R11 no effect", last_code, 12'h777);
    check(irq == 1'b1, "R10 done irq", irq, 1);
    wr(2'd2, 32'h1); repeat (2) @(negedge clk);
    check(irq == 1'b0, "R10 done irq clear", irq, 0);

    // R1/R5 random data and alignment
    for (int k = 0; k < 20; k++) begin
      d = $urandom();
      left = 1'($urandom_range(1));
      wr(2'd0, ctl(0, 0, 0, left, 0, 0, 0, 0));
      s0 = n_start;
      wr(2'd1, d); settle();
      check(n_start == s0 + 1, "R1 random", n_start - s0, 1);
      check(last_code == exp_code(d, left), "R5 random", last_code, exp_code(d, left));
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule